// File: doc/BRIEF.md
# Per-CPU Software Interrupt Pending Bank

This block keeps one 32-bit pending word for each processor in a multi-processor system and exposes every word at its output, so that a downstream combiner can merge it with other interrupt sources and drive the processor priority lines. The upper half of each word, bits 17 to 31, holds software interrupts. Software raises them and drops them through a small memory-mapped window per processor. The lower half, bits 1 to 15, follows hardware levels: a routed device level aimed at one processor, or that processor's own timer.

Software reaches the bank over a plain bus. A write takes one cycle with a strobe. A read strobe returns data one cycle later, marked by a response-valid pulse. The bus has no back-pressure: every strobe is accepted in the cycle it is presented, and the response-valid pulse carries no ready. The processor window is chosen by address bits 15:12, and the register within the window by address bits 3:2. Set and clear writes touch only the software bits. A clear write that carries bit 14 also drops bit 31, so the top software interrupt can be cleared through its hardware-level position.

Top module: `cpu_softirq_bank`

## Requirements
- R1: The window is selected by bus_addr[15:12] (one processor per 4 KB) and the register index by bus_addr[3:2]; bus_addr bits 11:4 and 1:0 have no effect.
- R2: A read presented on bus_rd returns, on the next cycle, bus_rvalid=1 and bus_rdata equal to the addressed processor's pending word as it stood before that edge when the index is 0; every other index, and any window at or above NCPU, returns 0. bus_rvalid is 0 in every cycle that does not follow a read.
- R3: A write to index 2 ORs (bus_wdata & 0xFFFE0000) into the addressed pending word.
- R4: A write to index 1 clears the bits of (bus_wdata & 0xFFFE0000) in the addressed word, and also clears bit 31 when bus_wdata[14] is 1.
- R5: Writes to index 0 or index 3, and writes to windows at or above NCPU, leave every pending word unchanged.
- R6: A cycle with lvl_evt=1 writes lvl_on into bit lvl_num of the pending word of processor lvl_cpu; lvl_num=0 and lvl_cpu at or above NCPU are ignored.
- R7: A 0-to-1 change of tmr_lvl[i] sets bit TMR_BIT (default 14) of processor i's word, and a 1-to-0 change clears it; a steady level changes nothing.
- R8: When several updates reach one word in the same cycle, the software set or clear applies first, then the level event, then the timer change. Each bit takes the last update that names it.
- R9: Reset clears all pending words, bus_rdata and bus_rvalid to 0.
- R10: Each pending word shows its new value in the cycle after the triggering edge, and bits 0 and 16 of every word stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 16 | Byte address: [15:12] window, [3:2] index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read response valid, one cycle after bus_rd |
| lvl_evt | input | 1 | Hardware level update strobe |
| lvl_cpu | input | 4 | Target processor of the level update |
| lvl_num | input | 4 | Level number (bit position) to update |
| lvl_on | input | 1 | New value for the level bit |
| tmr_lvl | input | NCPU | Per-processor timer level |
| pend_words | output | NCPU*32 | All pending words, processor i at [32*i+31:32*i] |

## Verification
The hardest case to reach is a single cycle in which a software write, a level event and a timer edge all land on the same word. Bit 14 is the critical point: it is a clear alias for bit 31 and also the default timer bit. The bench builds this cycle directly by driving a clear write with bit 14 set, a level event and a timer transition at the same falling edge. It repeats the cycle with the level event and the timer naming the same bit in opposite directions, so the ordering rule decides the result. A behavioural model updated on every edge is compared against all words and against each read response.

// File: rtl/softirq_pkg.sv
package softirq_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;
  localparam int ALIAS_BIT = 14;
  localparam int TOP_SOFT_BIT = 31;

  typedef enum logic [1:0] {
    IDX_PEND = 2'd0,
    IDX_CLR  = 2'd1,
    IDX_SET  = 2'd2,
    IDX_RSVD = 2'd3
  } reg_idx_e;

  function automatic logic [WORD_W-1:0] clr_mask(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] m;
    m = d;
    if (d[ALIAS_BIT]) m[TOP_SOFT_BIT] = 1'b1;
    return m & SOFT_MASK;
  endfunction
endpackage

// File: rtl/softirq_addr_dec.sv
module softirq_addr_dec
  import softirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [15:0]     addr,
  input  logic            wr,
  output logic [3:0]      cpu_sel,
  output logic            cpu_hit,
  output reg_idx_e        idx,
  output logic [NCPU-1:0] wr_set,
  output logic [NCPU-1:0] wr_clr
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[11:4], addr[1:0]};

  assign cpu_sel = addr[15:12];
  assign idx     = reg_idx_e'(addr[3:2]);
  assign cpu_hit = (32'(cpu_sel) < NCPU);

  always_comb begin
    wr_set = '0;
    wr_clr = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (wr && cpu_sel == 4'(i)) begin
        wr_set[i] = (idx == IDX_SET);
        wr_clr[i] = (idx == IDX_CLR);
      end
    end
  end
endmodule

// File: rtl/softirq_hw_upd.sv
module softirq_hw_upd
  import softirq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int TMR_BIT = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lvl_evt,
  input  logic [3:0]                   lvl_cpu,
  input  logic [3:0]                   lvl_num,
  input  logic                         lvl_on,
  input  logic [NCPU-1:0]              tmr_lvl,
  output logic [NCPU-1:0][WORD_W-1:0]  hw_set,
  output logic [NCPU-1:0][WORD_W-1:0]  hw_clr
);
  logic [NCPU-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_lvl;
  end

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (lvl_evt && lvl_cpu == 4'(i) && lvl_num != 4'd0) begin
        if (lvl_on) hw_set[i][lvl_num] = 1'b1;
        else        hw_clr[i][lvl_num] = 1'b1;
      end
      if (tmr_lvl[i] && !tmr_q[i]) begin
        hw_set[i][TMR_BIT] = 1'b1;
        hw_clr[i][TMR_BIT] = 1'b0;
      end else if (!tmr_lvl[i] && tmr_q[i]) begin
        hw_set[i][TMR_BIT] = 1'b0;
        hw_clr[i][TMR_BIT] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/softirq_pend_reg.sv
module softirq_pend_reg
  import softirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sw_set,
  input  logic [WORD_W-1:0] sw_clr,
  input  logic [WORD_W-1:0] hw_set,
  input  logic [WORD_W-1:0] hw_clr,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] after_sw;

  assign after_sw = (q & ~sw_clr) | sw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (after_sw & ~hw_clr) | hw_set;
  end
endmodule

// File: rtl/softirq_rd_port.sv
module softirq_rd_port
  import softirq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd,
  input  logic [3:0]                  cpu_sel,
  input  logic                        cpu_hit,
  input  reg_idx_e                    idx,
  input  logic [NCPU-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]           rdata,
  output logic                        rvalid
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (cpu_sel == 4'(i)) sel_word = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= (rd && cpu_hit && idx == IDX_PEND) ? sel_word : '0;
    end
  end
endmodule

// File: rtl/cpu_softirq_bank.sv
module cpu_softirq_bank
  import softirq_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int TMR_BIT = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [15:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic               lvl_evt,
  input  logic [3:0]         lvl_cpu,
  input  logic [3:0]         lvl_num,
  input  logic               lvl_on,
  input  logic [NCPU-1:0]    tmr_lvl,
  output logic [NCPU*32-1:0] pend_words
);
  logic [3:0]                  cpu_sel;
  logic                        cpu_hit;
  reg_idx_e                    idx;
  logic [NCPU-1:0]             wr_set;
  logic [NCPU-1:0]             wr_clr;
  logic [NCPU-1:0][WORD_W-1:0] hw_set;
  logic [NCPU-1:0][WORD_W-1:0] hw_clr;
  logic [NCPU-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0]           set_val;
  logic [WORD_W-1:0]           clr_val;

  assign set_val = bus_wdata & SOFT_MASK;
  assign clr_val = clr_mask(bus_wdata);

  softirq_addr_dec #(.NCPU(NCPU)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .cpu_sel (cpu_sel),
    .cpu_hit (cpu_hit),
    .idx     (idx),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr)
  );

  softirq_hw_upd #(.NCPU(NCPU), .TMR_BIT(TMR_BIT)) u_hw (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_evt (lvl_evt),
    .lvl_cpu (lvl_cpu),
    .lvl_num (lvl_num),
    .lvl_on  (lvl_on),
    .tmr_lvl (tmr_lvl),
    .hw_set  (hw_set),
    .hw_clr  (hw_clr)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    softirq_pend_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_set (wr_set[g] ? set_val : '0),
      .sw_clr (wr_clr[g] ? clr_val : '0),
      .hw_set (hw_set[g]),
      .hw_clr (hw_clr[g]),
      .q      (words[g])
    );
  end

  softirq_rd_port #(.NCPU(NCPU)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (bus_rd),
    .cpu_sel (cpu_sel),
    .cpu_hit (cpu_hit),
    .idx     (idx),
    .words   (words),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  assign pend_words = words;
endmodule

// File: rtl/cpu_softirq_bank_chk.sv
module cpu_softirq_bank_chk #(
  parameter int NCPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [15:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic               lvl_evt,
  input logic [NCPU-1:0]    tmr_lvl,
  input logic [NCPU*32-1:0] pend_words
);
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pend_words == '0 && !bus_rvalid && bus_rdata == '0));

  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r2_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  a_r2_other_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] != 2'd0) |=> bus_rdata == 32'd0);

  a_r5_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[3:2] == 2'd0 || bus_addr[3:2] == 2'd3) &&
     !lvl_evt && tmr_lvl == '0 && $stable(tmr_lvl)) |=> $stable(pend_words));

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    a_r10_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_words[32*g] == 1'b0 && pend_words[32*g+16] == 1'b0));

    a_r3_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:12] == 4'(g) && bus_addr[3:2] == 2'd2) |=>
      ((pend_words[32*g +: 32] & ($past(bus_wdata) & 32'hFFFE_0000)) ==
       ($past(bus_wdata) & 32'hFFFE_0000)));

    a_r4_clear_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:12] == 4'(g) && bus_addr[3:2] == 2'd1) |=>
      ((pend_words[32*g +: 32] &
        (($past(bus_wdata) | {$past(bus_wdata[14]), 31'd0}) & 32'hFFFE_0000)) == 32'd0));
  end
endmodule

bind cpu_softirq_bank cpu_softirq_bank_chk #(.NCPU(NCPU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .lvl_evt    (lvl_evt),
  .tmr_lvl    (tmr_lvl),
  .pend_words (pend_words)
);

// File: tb/sim_cpu_softirq_bank.sv
`timescale 1ns/1ps
module sim_cpu_softirq_bank;
  localparam int N = 4;
  localparam int TB = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic lvl_evt = 1'b0;
  logic [3:0] lvl_cpu = '0, lvl_num = '0;
  logic lvl_on = 1'b0;
  logic [N-1:0] tmr_lvl = '0;
  logic [N*32-1:0] pend_words;

  always #2.5 clk = ~clk;

  cpu_softirq_bank #(.NCPU(N), .TMR_BIT(TB)) u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  string cur = "R9";
  logic [31:0] m [N];
  logic [N-1:0] mt;
  logic exp_rv;
  logic [31:0] exp_rd;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m[i] = 0;
      mt = 0; exp_rv = 0; exp_rd = 0;
    end else begin
      int c;
      logic [31:0] k;
      c = int'(bus_addr[15:12]);
      exp_rv = bus_rd;
      exp_rd = (bus_rd && bus_addr[3:2] == 0 && c < N) ? m[c] : 32'd0;
      if (bus_wr && c < N) begin
        if (bus_addr[3:2] == 2'd1) begin
          k = bus_wdata & 32'hFFFE_0000;
          if (bus_wdata[14]) k[31] = 1'b1;
          m[c] = m[c] & ~k;
        end else if (bus_addr[3:2] == 2'd2) begin
          m[c] = m[c] | (bus_wdata & 32'hFFFE_0000);
        end
      end
      if (lvl_evt && int'(lvl_cpu) < N && lvl_num != 0) m[lvl_cpu][lvl_num] = lvl_on;
      for (int i = 0; i < N; i++) if (tmr_lvl[i] != mt[i]) m[i][TB] = tmr_lvl[i];
      mt = tmr_lvl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    for (int i = 0; i < N; i++) chk(cur, pend_words[32*i +: 32], m[i]);
    chk("R2", {31'd0, bus_rvalid}, {31'd0, exp_rv});
    if (exp_rv) chk("R2", bus_rdata, exp_rd);
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask
  task automatic rd(input logic [15:0] a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic lvl(input logic [3:0] c, input logic [3:0] n, input logic on);
    lvl_evt = 1; lvl_cpu = c; lvl_num = n; lvl_on = on;
    @(negedge clk); lvl_evt = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    cur = "R9";
    chk("R9", pend_words[31:0], 32'd0);
    chk("R9", bus_rdata, 32'd0);
    rst_n = 1;
    idle(1);
    cur = "R3";
    wr(16'h0008, 32'hFFFF_FFFF);
    rd(16'h0000);
    wr(16'h3008, 32'h8002_0001);
    rd(16'h3000);
    cur = "R1";
    wr(16'h2FF9, 32'h0004_0000);
    rd(16'h27F2);
    cur = "R4";
    wr(16'h0004, 32'h0002_4000);
    rd(16'h0000);
    wr(16'h3004, 32'h0000_4000);
    rd(16'h3000);
    cur = "R5";
    wr(16'h1000, 32'hFFFF_FFFF);
    wr(16'h100C, 32'hFFFF_FFFF);
    wr(16'h7008, 32'hFFFF_FFFF);
    rd(16'h1000);
    cur = "R2";
    rd(16'h0004); rd(16'h000C); rd(16'h5000); rd(16'h2000);
    cur = "R6";
    lvl(4'd1, 4'd5, 1'b1);
    lvl(4'd1, 4'd15, 1'b1);
    lvl(4'd1, 4'd0, 1'b1);
    lvl(4'd9, 4'd3, 1'b1);
    rd(16'h1000);
    lvl(4'd1, 4'd5, 1'b0);
    rd(16'h1000);
    cur = "R7";
    tmr_lvl[2] = 1; idle(3);
    rd(16'h2000);
    tmr_lvl[2] = 0; idle(2);
    tmr_lvl = 4'b1011; idle(2);
    cur = "R8";
    wr(16'h0008, 32'h8000_0000);
    bus_wr = 1; bus_addr = 16'h0004; bus_wdata = 32'h8002_4000;
    lvl_evt = 1; lvl_cpu = 0; lvl_num = 4'd14; lvl_on = 1;
    tmr_lvl[0] = 0;
    @(negedge clk); bus_wr = 0; lvl_evt = 0;
    rd(16'h0000);
    bus_wr = 1; bus_addr = 16'h1008; bus_wdata = 32'h0010_0000;
    lvl_evt = 1; lvl_cpu = 1; lvl_num = 4'd14; lvl_on = 0;
    tmr_lvl[1] = 0;
    @(negedge clk); bus_wr = 0; lvl_evt = 0;
    lvl_evt = 1; lvl_cpu = 3; lvl_num = 4'd14; lvl_on = 1; tmr_lvl[3] = 0;
    @(negedge clk); lvl_evt = 0;
    rd(16'h3000);
    cur = "R10";
    wr(16'h2008, 32'h0001_0000);
    lvl(4'd2, 4'd1, 1'b1);
    rd(16'h2000);
    cur = "R9";
    rst_n = 0; idle(2);
    chk("R9", pend_words, '0);
    rst_n = 1; idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule